// File: doc/BRIEF.md
# Programmable CPU Watchdog with Output Steering

This block watches a processor for signs of life. Software programs one 8-bit control register with a 5-bit multiplier, a 2-bit resolution code and a steering bit. The product of the multiplier and the resolution gives a timeout period. Any read or write of the control register counts as a sign of life and restarts the period. If no access arrives before the period runs out, the block acts in one of two ways, chosen by the steering bit.

With the steering bit clear, the block raises a sticky watchdog flag and drives the interrupt request from it. With the steering bit set, it emits a reset pulse of fixed width and wipes its own configuration, so the watchdog is disabled after the reset. A frequency-test request bit sits beside the register. Its enable is granted only while the watchdog is not steered to the interrupt pin.

Time is counted in 1/16 s units from a single-cycle 16 Hz tick enable supplied by the system.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset the control register reads 00h, and the frequency-test bit, flag, interrupt, reset pulse and frequency-test enable are all 0.
- R2: The control register is laid out as bit 7 steering, bits 6..2 multiplier, and bits 1..0 resolution. The resolution codes 00, 01, 10 and 11 mean 1, 4, 16 and 64 ticks. The timeout fires on the tick that makes the count since the last register access equal to the multiplier times the resolution. Its effect is visible in the clock cycle after that tick.
- R3: A read strobe or a write strobe on the control register restarts the count from zero, and no timeout fires in that cycle.
- R4: When the multiplier field is zero, no timeout is ever produced. This covers the value 00h and also a zero multiplier with a nonzero resolution.
- R5: With steering 0, a timeout sets the watchdog flag, and the interrupt output follows the flag. The flag holds until either a flags-register read strobe or an access to the control register.
- R6: With steering 1, a timeout raises the reset output for PULSE_TICKS ticks (default 2). The output falls on the PULSE_TICKS-th tick after the timeout. The watchdog flag is not set.
- R7: A steering-1 timeout clears the control register and the frequency-test bit in the same edge that raises the reset output. No further timeout follows.
- R8: The frequency-test enable is 1 only when two conditions hold: the frequency-test bit is 1, and either the steering bit is 1 or the control register is 00h.
- R9: The read-data port always shows the current control register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16 Hz timebase, one cycle wide |
| reg_rd_i | input | 1 | Control register read strobe |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register contents |
| flag_rd_i | input | 1 | Flags register read strobe |
| ft_wr_i | input | 1 | Frequency-test bit write strobe |
| ft_wdata_i | input | 1 | Frequency-test bit write value |
| ft_bit_o | output | 1 | Frequency-test bit contents |
| ft_en_o | output | 1 | Frequency test granted |
| wd_flag_o | output | 1 | Watchdog flag |
| irq_o | output | 1 | Interrupt request, active high |
| wdt_rst_o | output | 1 | Watchdog reset pulse, active high |

## Verification
The bench checks timeout boundaries for every resolution code. At one tick before the limit, nothing must happen; at the limit, the timeout must fire. An off-by-one counter or a wrong shift moves the event by a tick or by a factor of four. Restarts are issued in the middle of a count, both through reads and through writes. A design that ignored reads as signs of life would fire early. The reset-steered path is checked for the exact pulse width and for the clearing of the register and the frequency-test bit. A design that kept its configuration would fire a second reset. The bench also covers disable through a zero multiplier with a nonzero resolution, and frequency-test suppression in each steering state.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int NRES   = 1 << RES_W;
  localparam int CFG_W  = 1 + MULT_W + RES_W;
  localparam int CNT_W  = MULT_W + 2 * (NRES - 1);

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             ft_wr_i,
  input  logic             ft_wdata_i,
  input  logic             clr_i,
  output wdog_cfg_t        cfg_o,
  output logic             ft_bit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= '0;
      ft_bit_o <= 1'b0;
    end else begin
      if (clr_i)     cfg_o <= '0;
      else if (wr_i) cfg_o <= wdog_cfg_t'(wdata_i);
      if (clr_i)        ft_bit_o <= 1'b0;
      else if (ft_wr_i) ft_bit_o <= ft_wdata_i;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      restart_i,
  input  wdog_cfg_t cfg_i,
  output logic      expire_o
);
  logic [CNT_W-1:0] term_opts [NRES];
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt, cnt_inc;
  logic             enabled;

  // one terminal count per resolution code: 4^code ticks per unit
  for (genvar g = 0; g < NRES; g++) begin : g_term
    assign term_opts[g] = CNT_W'(cfg_i.mult) << (2 * g);
  end

  assign term     = term_opts[cfg_i.res];
  assign enabled  = |cfg_i.mult;
  assign cnt_inc  = cnt + 1'b1;
  assign expire_o = enabled && tick_i && !restart_i && (cnt_inc == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt <= '0;
    else if (restart_i || !enabled)   cnt <= '0;
    else if (expire_o)                cnt <= '0;
    else if (tick_i)                  cnt <= cnt_inc;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic active_o
);
  localparam int PW = $clog2(PULSE_TICKS + 1);
  logic [PW-1:0] left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                left <= '0;
    else if (start_i)           left <= PW'(PULSE_TICKS);
    else if (tick_i && |left)   left <= left - 1'b1;
  end

  assign active_o = |left;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int PULSE_TICKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [CFG_W-1:0] reg_wdata_i,
  output logic [CFG_W-1:0] reg_rdata_o,
  input  logic             flag_rd_i,
  input  logic             ft_wr_i,
  input  logic             ft_wdata_i,
  output logic             ft_bit_o,
  output logic             ft_en_o,
  output logic             wd_flag_o,
  output logic             irq_o,
  output logic             wdt_rst_o
);
  wdog_cfg_t cfg;
  logic      restart, expire, exp_irq, exp_rst, flag_q;

  assign restart = reg_rd_i | reg_wr_i;
  assign exp_irq = expire & ~cfg.steer;
  assign exp_rst = expire &  cfg.steer;

  wdog_cfg_reg u_cfg (
    .clk_i, .rst_ni,
    .wr_i       (reg_wr_i),
    .wdata_i    (reg_wdata_i),
    .ft_wr_i,
    .ft_wdata_i,
    .clr_i      (exp_rst),
    .cfg_o      (cfg),
    .ft_bit_o
  );

  wdog_timer u_timer (
    .clk_i, .rst_ni, .tick_i,
    .restart_i (restart),
    .cfg_i     (cfg),
    .expire_o  (expire)
  );

  wdog_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk_i, .rst_ni, .tick_i,
    .start_i  (exp_rst),
    .active_o (wdt_rst_o)
  );

  // a new timeout wins over a same-cycle flag read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (exp_irq)                flag_q <= 1'b1;
    else if (flag_rd_i || restart)   flag_q <= 1'b0;
  end

  assign wd_flag_o   = flag_q;
  assign irq_o       = flag_q;
  assign reg_rdata_o = cfg;
  assign ft_en_o     = ft_bit_o & (cfg.steer | ~|cfg);
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       reg_rd_i,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       flag_rd_i,
  input logic       ft_wr_i,
  input logic       ft_wdata_i,
  input logic       ft_bit_o,
  input logic       ft_en_o,
  input logic       wd_flag_o,
  input logic       irq_o,
  input logic       wdt_rst_o
);
  AST_FLAG_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_flag_o) |-> $past(tick_i)); // R2
  AST_ACCESS_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i || reg_wr_i) |=> !wd_flag_o); // R3
  AST_ZERO_MULT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[6:2] == 5'd0 && !wd_flag_o) |=> !wd_flag_o); // R4
  AST_IRQ_TRACKS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_flag_o) |-> irq_o); // R5
  AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> $past(tick_i)); // R6
  AST_PULSE_WIPES_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> (reg_rdata_o == 8'h00 && !ft_bit_o)); // R7
  AST_FT_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ft_en_o |-> ft_bit_o); // R8
endmodule

bind wdog_ctrl wdog_ctrl_chk u_wdog_chk (.*);

// File: tb/wdog_ctrl_test.sv
module wdog_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, rd = 1'b0, wr = 1'b0, frd = 1'b0, ftwr = 1'b0, ftd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ft_bit, ft_en, flag, irq, wrst;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  wdog_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .flag_rd_i(frd), .ft_wr_i(ftwr),
    .ft_wdata_i(ftd), .ft_bit_o(ft_bit), .ft_en_o(ft_en), .wd_flag_o(flag),
    .irq_o(irq), .wdt_rst_o(wrst)
  );

  function automatic int exp_ticks(logic [7:0] c);
    return int'(c[6:2]) << (2 * int'(c[1:0]));
  endfunction

  function automatic bit exp_ft_en(logic [7:0] c, logic b);
    return b && (c[7] || c == 8'h00);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic reg_write(logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic flag_read();
    @(negedge clk); frd = 1'b1;
    @(negedge clk); frd = 1'b0;
  endtask

  task automatic ft_write(logic b);
    @(negedge clk); ftwr = 1'b1; ftd = b;
    @(negedge clk); ftwr = 1'b0;
  endtask

  // program, then verify silence one tick early and firing on the limit
  task automatic timeout_run(logic [7:0] c);
    int t = exp_ticks(c);
    reg_write(c);
    check("R9 readback", rdata, c);
    ticks(t - 1);
    check("R2 no flag one tick early", flag, 0);
    do_tick();
    check("R2 flag at limit", flag, 1);
    check("R5 irq follows flag", irq, 1);
    check("R6 no reset when steered to irq", wrst, 0);
    reg_read();
    check("R5 access clears flag", flag, 0);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog: actual 1 expected 0");
          $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 0);
    check("R1 ft_bit", ft_bit, 0);
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);
    check("R1 wdt_rst", wrst, 0);
    check("R1 ft_en", ft_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 disabled by default and with zero multiplier
    ticks(80);
    check("R4 off at 00h flag", flag, 0);
    check("R4 off at 00h reset", wrst, 0);
    reg_write(8'h83);
    ticks(80);
    check("R4 zero mult flag", flag, 0);
    check("R4 zero mult reset", wrst, 0);
    reg_write(8'h02);
    ticks(40);
    check("R4 zero mult res10 flag", flag, 0);

    // R2 every resolution with multiplier 1, and the 3-unit example
    for (int r = 0; r < 4; r++) timeout_run(8'h04 | 8'(r));
    timeout_run(8'h0E);

    // R5 flag holds until the flags read strobe
    reg_write(8'h04);
    do_tick();
    check("R5 flag set", flag, 1);
    repeat (5) @(negedge clk);
    check("R5 flag holds", flag, 1);
    flag_read();
    check("R5 flags read clears", flag, 0);
    check("R5 irq clears", irq, 0);

    // R3 restart by read and by write mid-count (8 ticks)
    reg_write(8'h09);
    ticks(5);
    reg_read();
    ticks(7);
    check("R3 read restarts", flag, 0);
    do_tick();
    check("R3 fires after read restart", flag, 1);
    reg_write(8'h09);
    ticks(6);
    reg_write(8'h09);
    ticks(7);
    check("R3 write restarts", flag, 0);
    do_tick();
    check("R3 fires after write restart", flag, 1);
    reg_read();

    // random configurations, irq steering
    for (int i = 0; i < 10; i++) begin
      logic [7:0] c;
      logic [1:0] r = 2'($urandom_range(0, 3));
      logic [4:0] m = (r == 2'd3) ? 5'($urandom_range(1, 4)) : 5'($urandom_range(1, 31));
      c = {1'b0, m, r};
      timeout_run(c);
    end

    // R8 frequency-test grant rules
    ft_write(1'b1);
    reg_write(8'h00);
    check("R8 ft granted at 00h", ft_en, exp_ft_en(rdata, ft_bit));
    check("R8 ft granted at 00h literal", ft_en, 1);
    reg_write(8'h05);
    check("R8 ft denied while steered to irq", ft_en, 0);
    reg_write(8'h85);
    check("R8 ft granted when steered to reset", ft_en, 1);
    ft_write(1'b0);
    check("R8 ft off without bit", ft_en, 0);

    // R6/R7 reset steering: multiplier 1, resolution 1 tick
    ft_write(1'b1);
    reg_write(8'h84);
    do_tick();
    check("R6 reset raised", wrst, 1);
    check("R6 flag not set", flag, 0);
    check("R7 register cleared", rdata, 0);
    check("R7 ft bit cleared", ft_bit, 0);
    do_tick();
    check("R6 reset still high after 1 tick", wrst, 1);
    do_tick();
    check("R6 reset low after 2 ticks", wrst, 0);
    ticks(20);
    check("R7 no second reset", wrst, 0);

    // R6 with a longer period (4 units of 4 ticks)
    reg_write(8'h91);
    ticks(15);
    check("R6 silent one tick early", wrst, 0);
    do_tick();
    check("R6 reset at limit", wrst, 1);
    check("R7 cleared after long period", rdata, 0);
    ticks(2);
    check("R6 pulse ended", wrst, 0);

    // R9 random readback
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d = 8'($urandom);
      reg_write(d);
      check("R9 readback random", rdata, d);
      check("R8 ft_en random", ft_en, exp_ft_en(d, ft_bit));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule